// File: doc/BRIEF.md
# Synchronous FIFO with Instant Replay

This block is a single-clock first-in first-out buffer, 36 bits wide and 1,024 words deep by default. Words enter through a valid/ready write stream and leave through a valid/ready read stream. The read side is first-word-fall-through: the oldest unread word is driven on the read data bus whenever the buffer holds data. An active-low output enable masks the read data bus to zero when it is high. Three status outputs report occupancy against programmable levels: almost empty, more than half full, and almost full.

On top of ordinary buffering, the block can replay the stream. A replay request rewinds the read side to the first word written since reset. The rewind happens on the request edge. In the very next cycle that word is on the output, and no extra read cycle is needed. Replay is only honoured when it has been enabled by a mode pin captured during reset, at least two words have been written since reset, and the writes since reset have not exceeded the depth minus two. Because of that last limit the write side never wraps over the stored history.

Back-pressure works as follows. A write is accepted on a clock edge where `wr_valid` and `wr_ready` are both high, and `wr_ready` is low exactly when the buffer is full. A read is taken on an edge where `rd_valid` and `rd_ready` are both high, and `rd_valid` is high exactly when the buffer is not empty. Either side may hold its signal for as long as it likes. Nothing is lost or duplicated while the other side stalls.

Top module: `fifo_rt`

## Requirements
- R1: While `rst_n` is low at a clock edge, the buffer is emptied. After reset, `rd_valid` is 0, `wr_ready` is 1, `almost_empty` is 1, and `half_full` and `almost_full` are 0.
- R2: Words are returned in the order they were written. The oldest unread word is on `rd_data` whenever `rd_valid` is 1 and `out_en_n` is 0. That word stays stable until it is read or a replay takes effect.
- R3: `wr_ready` is 0 exactly when DEPTH words are held. A write offered while `wr_ready` is 0 is dropped and stores nothing.
- R4: While `out_en_n` is 1, `rd_data` is all zeros. While it is 0, `rd_data` shows the head word.
- R5: The flags are decoded from the occupancy N held after each clock edge. `almost_empty` = (N <= AE_OFS), `half_full` = (N > DEPTH/2), `almost_full` = (N >= DEPTH - AF_OFS).
- R6: An accepted replay makes the first word written since reset the head in the next cycle, with no read needed. Later reads return the second word, the third word, and so on.
- R7: After an accepted replay, the occupancy equals the number of words written since reset, counting a write accepted in the same cycle. All three flags reflect that restored occupancy.
- R8: `rd_ready` has no effect in a cycle where a replay is accepted, so the first word is not consumed.
- R9: A replay requested when fewer than two words have been written since reset is ignored, and the head and occupancy are unchanged.
- R10: A replay requested after more than DEPTH-2 words have been written since reset is ignored, and the head and occupancy are unchanged.
- R11: If `zl_mode_n` is 1 during reset, replay is disabled until the next reset and every request is ignored. A value of 0 enables it.
- R12: A replay accepted while the buffer is empty raises `rd_valid` in the next cycle, with the first word on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low synchronous master reset |
| zl_mode_n | input | 1 | Replay mode, captured while reset is low; 0 enables replay |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Buffer can accept a word (not full) |
| wr_data | input | W | Write word |
| rd_valid | output | 1 | Head word present (not empty) |
| rd_ready | input | 1 | Consumer takes the head word |
| rd_data | output | W | Head word, zero while output enable is inactive |
| out_en_n | input | 1 | Active-low output enable for `rd_data` |
| rt_req | input | 1 | Replay request, sampled on the rising edge |
| almost_empty | output | 1 | Occupancy at or below AE_OFS |
| half_full | output | 1 | Occupancy above DEPTH/2 |
| almost_full | output | 1 | Occupancy at or above DEPTH-AF_OFS |

## Verification
Some rules are checked by the assertions on every cycle. These are the reset state, that a full buffer stays full while nothing is read, that the head word holds still while stalled, the output-enable masking, that an empty buffer reports consistent flags, and that an accepted replay always leaves data valid. Other behaviour can only be shown by the directed scenarios. That covers the replayed order, the restored occupancy and flag levels, the rejection of replays under each forbidden condition, and the dropping of both a read and a write in the cases where they must have no effect. Those scenarios check the first word and every later word against the sequence the bench itself wrote.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  // Occupancy status bundle produced by the flag decoder.
  typedef struct packed {
    logic almost_empty;
    logic half_full;
    logic almost_full;
  } fifo_rt_status_t;
endpackage

// File: rtl/fifo_rt_store.sv
module fifo_rt_store #(
  parameter int W     = 36,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Combinational read gives fall-through and zero-latency rewind.
  assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          zl_mode_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          rt_req,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push,
  output logic          rt_fire
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] TOT_MAX = CW'(DEPTH - 1);
  localparam logic [CW-1:0] RT_MAX  = CW'(DEPTH - 2);
  localparam logic [CW-1:0] RT_MIN  = CW'(2);

  logic [CW-1:0] wr_total;   // writes since reset, saturating
  logic          zl_en;      // replay enabled, captured at reset
  logic          pop;
  logic          rt_ok;

  always_comb begin
    full    = (count == DEPTH_C);
    empty   = (count == '0);
    push    = push_req & ~full;
    rt_ok   = zl_en && (wr_total >= RT_MIN) && (wr_total <= RT_MAX);
    rt_fire = rt_req & rt_ok;
    pop     = pop_req & ~empty & ~rt_fire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      wr_total <= '0;
      zl_en    <= ~zl_mode_n;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (push && (wr_total != TOT_MAX)) wr_total <= wr_total + 1'b1;
      if (rt_fire) begin
        rd_ptr <= '0;
        count  <= wr_total + CW'(push);
      end else begin
        if (pop) rd_ptr <= rd_ptr + 1'b1;
        count <= count + CW'(push) - CW'(pop);
      end
    end
  end
endmodule

// File: rtl/fifo_rt_flags.sv
module fifo_rt_flags
  import fifo_rt_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int AE_OFS = 8,
  parameter int AF_OFS = 8,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic [CW-1:0]   count,
  output fifo_rt_status_t status
);
  localparam logic [CW-1:0] AE_LVL = CW'(AE_OFS);
  localparam logic [CW-1:0] HF_LVL = CW'(DEPTH / 2);
  localparam logic [CW-1:0] AF_LVL = CW'(DEPTH - AF_OFS);

  always_comb begin
    status.almost_empty = (count <= AE_LVL);
    status.half_full    = (count > HF_LVL);
    status.almost_full  = (count >= AF_LVL);
  end
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt
  import fifo_rt_pkg::*;
#(
  parameter int W      = 36,
  parameter int DEPTH  = 1024,
  parameter int AE_OFS = 8,
  parameter int AF_OFS = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         zl_mode_n,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [W-1:0] wr_data,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data,
  input  logic         out_en_n,
  input  logic         rt_req,
  output logic         almost_empty,
  output logic         half_full,
  output logic         almost_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   count;
  logic            full, empty, push, rt_fire;
  logic [W-1:0]    head;
  fifo_rt_status_t status;

  fifo_rt_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .zl_mode_n(zl_mode_n),
    .push_req (wr_valid),
    .pop_req  (rd_ready),
    .rt_req   (rt_req),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .count    (count),
    .full     (full),
    .empty    (empty),
    .push     (push),
    .rt_fire  (rt_fire)
  );

  fifo_rt_store #(.W(W), .DEPTH(DEPTH)) store_i (
    .clk  (clk),
    .we   (push),
    .waddr(wr_ptr),
    .wdata(wr_data),
    .raddr(rd_ptr),
    .rdata(head)
  );

  fifo_rt_flags #(.DEPTH(DEPTH), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)) flags_i (
    .count (count),
    .status(status)
  );

  assign wr_ready     = ~full;
  assign rd_valid     = ~empty;
  assign rd_data      = out_en_n ? '0 : head;
  assign almost_empty = status.almost_empty;
  assign half_full    = status.half_full;
  assign almost_full  = status.almost_full;
endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk #(
  parameter int W = 36
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_ready,
  input logic         rd_valid,
  input logic         rd_ready,
  input logic [W-1:0] rd_data,
  input logic         out_en_n,
  input logic         rt_fire,
  input logic         almost_empty,
  input logic         half_full,
  input logic         almost_full
);
  p_reset_state_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!rd_valid && wr_ready && almost_empty));

  p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !rd_ready) |=> !wr_ready);

  p_head_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !rt_fire && !out_en_n) |=> (out_en_n || $stable(rd_data)));

  p_oe_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (rd_data == '0));

  p_empty_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (almost_empty && !half_full && !almost_full));

  p_replay_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rt_fire |=> rd_valid);
endmodule

bind fifo_rt fifo_rt_chk #(.W(W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_ready    (wr_ready),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .rd_data     (rd_data),
  .out_en_n    (out_en_n),
  .rt_fire     (rt_fire),
  .almost_empty(almost_empty),
  .half_full   (half_full),
  .almost_full (almost_full)
);

// File: tb/fifo_rt_tb_top.sv
`timescale 1ns/1ps
module fifo_rt_tb_top;
  localparam int W = 36, DEPTH = 16, AE = 2, AF = 2;

  logic clk = 1'b0, rst_n = 1'b0, zl_mode_n = 1'b0;
  logic wr_valid = 1'b0, rd_ready = 1'b0, out_en_n = 1'b0, rt_req = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic wr_ready, rd_valid, almost_empty, half_full, almost_full;
  logic [W-1:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fifo_rt #(.W(W), .DEPTH(DEPTH), .AE_OFS(AE), .AF_OFS(AF)) dut_i (
    .clk(clk), .rst_n(rst_n), .zl_mode_n(zl_mode_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .out_en_n(out_en_n), .rt_req(rt_req),
    .almost_empty(almost_empty), .half_full(half_full), .almost_full(almost_full)
  );

  function automatic logic [W-1:0] word(input int i);
    return W'(36'h5A000) + W'(i * 3);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic flags(input string req, input int n);
    chk(req, W'(almost_empty), W'(n <= AE));
    chk(req, W'(half_full),    W'(n > DEPTH / 2));
    chk(req, W'(almost_full),  W'(n >= DEPTH - AF));
    chk(req, W'(rd_valid),     W'(n != 0));
    chk(req, W'(wr_ready),     W'(n != DEPTH));
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; zl_mode_n = mode;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1; zl_mode_n = 1'b0;
  endtask

  task automatic push(input int i);
    wr_valid = 1'b1; wr_data = word(i);
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic pop_exp(input string req, input int i);
    chk(req, W'(rd_valid), W'(1));
    chk(req, rd_data, word(i));
    rd_ready = 1'b1;
    @(posedge clk); #1;
    rd_ready = 1'b0;
  endtask

  task automatic replay(input logic with_rd, input logic with_wr, input int wi);
    rt_req = 1'b1; rd_ready = with_rd; wr_valid = with_wr; wr_data = word(wi);
    @(posedge clk); #1;
    rt_req = 1'b0; rd_ready = 1'b0; wr_valid = 1'b0;
  endtask

  // R1 R2 R4 R5: reset state, order, output enable, flag levels
  task automatic t_basic();
    do_reset(1'b0);
    flags("R1", 0);
    for (int i = 0; i < 10; i++) begin
      push(i);
      flags("R5", i + 1);
    end
    out_en_n = 1'b1; #1;
    chk("R4", rd_data, '0);
    out_en_n = 1'b0; #1;
    chk("R4", rd_data, word(0));
    for (int i = 0; i < 10; i++) begin
      pop_exp("R2", i);
      flags("R5", 9 - i);
    end
  endtask

  // R3: full back-pressure drops the offered word
  task automatic t_full();
    do_reset(1'b0);
    for (int i = 0; i < DEPTH; i++) push(i);
    flags("R3", DEPTH);
    push(99);
    flags("R3", DEPTH);
    for (int i = 0; i < DEPTH; i++) pop_exp("R3", i);
    chk("R3", W'(rd_valid), W'(0));
  endtask

  // R6 R7 R8: replay with a read offered in the same cycle
  task automatic t_replay();
    do_reset(1'b0);
    for (int i = 0; i < 10; i++) push(i);
    for (int i = 0; i < 8; i++) pop_exp("R2", i);
    flags("R5", 2);
    replay(1'b1, 1'b0, 0);
    flags("R7", 10);
    chk("R8", rd_data, word(0));
    for (int i = 0; i < 10; i++) pop_exp("R6", i);
    chk("R6", W'(rd_valid), W'(0));
  endtask

  // R7: write accepted in the replay cycle is counted
  task automatic t_replay_wr();
    do_reset(1'b0);
    for (int i = 0; i < 3; i++) push(i);
    pop_exp("R2", 0); pop_exp("R2", 1);
    replay(1'b0, 1'b1, 3);
    flags("R7", 4);
    for (int i = 0; i < 4; i++) pop_exp("R7", i);
  endtask

  // R12: replay from empty
  task automatic t_replay_empty();
    do_reset(1'b0);
    for (int i = 0; i < 3; i++) push(i);
    for (int i = 0; i < 3; i++) pop_exp("R2", i);
    flags("R12", 0);
    replay(1'b0, 1'b0, 0);
    chk("R12", W'(rd_valid), W'(1));
    chk("R12", rd_data, word(0));
    for (int i = 0; i < 3; i++) pop_exp("R12", i);
  endtask

  // R9: too few writes
  task automatic t_reject_few();
    do_reset(1'b0);
    push(0);
    pop_exp("R9", 0);
    replay(1'b0, 1'b0, 0);
    flags("R9", 0);
  endtask

  // R10: too many writes
  task automatic t_reject_many();
    do_reset(1'b0);
    for (int i = 0; i < DEPTH - 1; i++) push(i);
    for (int i = 0; i < 5; i++) pop_exp("R10", i);
    replay(1'b0, 1'b0, 0);
    flags("R10", DEPTH - 6);
    for (int i = 5; i < DEPTH - 1; i++) pop_exp("R10", i);
  endtask

  // R11: mode pin high at reset disables replay
  task automatic t_reject_mode();
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) push(i);
    pop_exp("R11", 0); pop_exp("R11", 1);
    replay(1'b0, 1'b0, 0);
    flags("R11", 2);
    pop_exp("R11", 2); pop_exp("R11", 3);
  endtask

  initial begin
    t_basic();
    t_full();
    t_replay();
    t_replay_wr();
    t_replay_empty();
    t_reject_few();
    t_reject_many();
    t_reject_mode();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule